// File: doc/BRIEF.md
# Multiple-Miss-Ahead Prefetch Predictor

This block watches the stream of instruction-block misses reported by a small tag-only shadow directory. It learns, for each missing block, which block missed a fixed number of misses later, and it uses that knowledge to prefetch. It does not predict the immediately following miss. A circular history queue holds the most recent miss addresses. When a new miss arrives, the address that has aged exactly `LOOKAHEAD` positions is taken from the queue, and the table row it hashes to is written with the current address as its target.

On the same miss, the table is read at the current address. If the stored partial tag matches and the entry's real-cache-miss flag is set, a prefetch of the stored target is offered on a valid/ready output. The flag records whether the target block also missed the real instruction cache when it was learned. Prefetches that would only hit the real cache are therefore filtered out. The real cache and the downstream prefetch queue are outside this block.

Top module: `mma_predictor`

## Requirements
- R1: Only cycles with `missValid` high advance the history queue, train the table or start a prediction. `missAddr` and `realMiss` are ignored in other cycles.
- R2: On a miss that arrives once `LOOKAHEAD` earlier misses are queued, the table row of the miss exactly `LOOKAHEAD` misses earlier is written with the current address as target. The target is not the next miss.
- R3: The first `LOOKAHEAD` misses after reset perform no table write.
- R4: Row index = `addr[INDEX_W-1:0] ^ addr[2*INDEX_W-1:INDEX_W]` and partial tag = `addr[2*INDEX_W +: TAG_W]`. A prediction requires a written row whose stored tag equals the current address's tag.
- R5: Each training write stores the current `realMiss` as the row flag, setting or clearing it. A matching row with a clear flag produces no prefetch.
- R6: The lookup for a miss uses the table contents from before that miss's own training write. `pfValid` rises in the cycle after the miss is sampled.
- R7: While `pfValid` is high and `pfReady` is low, `pfValid` stays high and `pfAddr` holds its value. The request drops the cycle after `pfReady` is seen high, unless a new prediction loads.
- R8: A prediction made while a request is pending and not accepted is discarded. The pending address is kept.
- R9: After reset `pfValid` is low and every table row is unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Shadow-directory miss strobe |
| missAddr | input | ADDR_W | Block address of the miss |
| realMiss | input | 1 | The same access also missed the real cache |
| pfReady | input | 1 | Downstream accepts the prefetch |
| pfValid | output | 1 | Prefetch request pending |
| pfAddr | output | ADDR_W | Block address to prefetch |

## Verification
The bench builds the predictor with `LOOKAHEAD` = 4, `INDEX_W` = 3, `TAG_W` = 4 and `ADDR_W` = 16. A short lookahead lets a whole fill-train-predict cycle run in about five misses, so the warm-up gap, the distance to the predicted miss and retraining of one row all fit in brief directed sequences. The eight-row table makes a tag alias easy to build from addresses that differ only above the index bits.

// File: rtl/mma_pkg.sv
package mma_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic histWe;   // push current miss into history queue
    logic trainWe;  // write the aged entry's table row
    logic pfLoad;   // capture lookup target into the request register
  } mmaStrobe_t;
endpackage

// File: rtl/mma_ctrl.sv
module mma_ctrl
  import mma_pkg::*;
#(
  parameter int LOOKAHEAD = 30,
  localparam int PTR_W = (LOOKAHEAD > 1) ? $clog2(LOOKAHEAD) : 1,
  localparam int FILL_W = $clog2(LOOKAHEAD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic             predHit,
  input  logic             pfReady,
  output mmaStrobe_t       strb,
  output logic [PTR_W-1:0] histPtr,
  output logic             pfValid
);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(LOOKAHEAD);
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(LOOKAHEAD - 1);

  logic [FILL_W-1:0] fillCnt;
  logic queueFull;
  logic slotFree;

  assign queueFull = (fillCnt == FILL_MAX);
  assign slotFree  = !pfValid || pfReady;

  always_comb begin
    strb.histWe  = missValid;
    strb.trainWe = missValid && queueFull;
    strb.pfLoad  = missValid && predHit && slotFree;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      histPtr <= '0;
    end else if (missValid) begin
      if (!queueFull) fillCnt <= fillCnt + 1'b1;
      histPtr <= (histPtr == PTR_LAST) ? '0 : histPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pfValid <= 1'b0;
    else       pfValid <= strb.pfLoad | (pfValid & ~pfReady);
  end

  // A request can only appear as the result of a sampled miss
  assert_rise_after_miss_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(missValid));

  // Warm-up count moves only with misses
  assert_fill_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillCnt != FILL_MAX && !missValid) |=> $stable(fillCnt));

  // Pending request is held until accepted
  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> pfValid);
endmodule

// File: rtl/mma_datapath.sv
module mma_datapath
  import mma_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int INDEX_W = 6,
  parameter int TAG_W = 10,
  parameter int LOOKAHEAD = 30,
  localparam int PTR_W = (LOOKAHEAD > 1) ? $clog2(LOOKAHEAD) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              realMiss,
  input  mmaStrobe_t        strb,
  input  logic [PTR_W-1:0]  histPtr,
  input  logic              pfValid,
  input  logic              pfReady,
  output logic              predHit,
  output logic [ADDR_W-1:0] pfAddr
);
  localparam int ROWS = 1 << INDEX_W;

  function automatic logic [INDEX_W-1:0] rowOf(input logic [ADDR_W-1:0] a);
    return a[INDEX_W-1:0] ^ a[2*INDEX_W-1:INDEX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(input logic [ADDR_W-1:0] a);
    return a[2*INDEX_W +: TAG_W];
  endfunction

  logic [ADDR_W-1:0] histMem   [LOOKAHEAD];
  logic              rowValid  [ROWS];
  logic [TAG_W-1:0]  rowTag    [ROWS];
  logic [ADDR_W-1:0] rowTarget [ROWS];
  logic              rowFlag   [ROWS];

  logic [ADDR_W-1:0]  agedAddr;
  logic [INDEX_W-1:0] curRow;
  logic [INDEX_W-1:0] trainRow;

  assign agedAddr = histMem[histPtr];
  assign curRow   = rowOf(missAddr);
  assign trainRow = rowOf(agedAddr);
  assign predHit  = rowValid[curRow] && (rowTag[curRow] == tagOf(missAddr)) && rowFlag[curRow];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOOKAHEAD; i++) histMem[i] <= '0;
    end else if (strb.histWe) begin
      histMem[histPtr] <= missAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) begin
        rowValid[i]  <= 1'b0;
        rowTag[i]    <= '0;
        rowTarget[i] <= '0;
        rowFlag[i]   <= 1'b0;
      end
    end else if (strb.trainWe) begin
      rowValid[trainRow]  <= 1'b1;
      rowTag[trainRow]    <= tagOf(agedAddr);
      rowTarget[trainRow] <= missAddr;
      rowFlag[trainRow]   <= realMiss;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pfAddr <= '0;
    else if (strb.pfLoad) pfAddr <= rowTarget[curRow];
  end

  // Unaccepted request keeps its address, later predictions are dropped
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> $stable(pfAddr));
endmodule

// File: rtl/mma_predictor.sv
module mma_predictor
  import mma_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int INDEX_W = 6,
  parameter int TAG_W = 10,
  parameter int LOOKAHEAD = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              realMiss,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);
  localparam int PTR_W = (LOOKAHEAD > 1) ? $clog2(LOOKAHEAD) : 1;

  mmaStrobe_t       strb;
  logic [PTR_W-1:0] histPtr;
  logic             predHit;

  mma_ctrl #(.LOOKAHEAD(LOOKAHEAD)) uCtrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .predHit(predHit),
    .pfReady(pfReady), .strb(strb), .histPtr(histPtr), .pfValid(pfValid)
  );

  mma_datapath #(
    .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .TAG_W(TAG_W), .LOOKAHEAD(LOOKAHEAD)
  ) uData (
    .clk(clk), .rstN(rstN), .missAddr(missAddr), .realMiss(realMiss),
    .strb(strb), .histPtr(histPtr), .pfValid(pfValid), .pfReady(pfReady),
    .predHit(predHit), .pfAddr(pfAddr)
  );
endmodule

// File: tb/tb_mma_predictor.sv
`timescale 1ns/1ps
module tb_mma_predictor;
  localparam int ADDR_W = 16;
  localparam int INDEX_W = 3;
  localparam int TAG_W = 4;
  localparam int LOOKAHEAD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [ADDR_W-1:0] missAddr = '0;
  logic realMiss = 1'b0;
  logic pfReady = 1'b1;
  logic pfValid;
  logic [ADDR_W-1:0] pfAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mma_predictor #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .TAG_W(TAG_W), .LOOKAHEAD(LOOKAHEAD)) dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .realMiss(realMiss), .pfReady(pfReady), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  task automatic checkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; missValid = 1'b0; realMiss = 1'b0; missAddr = '0; pfReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Drive one miss; returns at the negedge after the sampling edge
  task automatic miss(input logic [ADDR_W-1:0] a, input logic rm);
    @(negedge clk);
    missValid = 1'b1; missAddr = a; realMiss = rm;
    @(negedge clk);
    missValid = 1'b0; realMiss = 1'b0;
  endtask

  task automatic testReset();
    resetDut();
    checkEq("R9", "pfValid after reset", 32'(pfValid), 32'd0);
  endtask

  task automatic testWarmup();
    resetDut();
    for (int i = 1; i <= 4; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0000, 1'b1);  // row of address 0 must still be empty
    checkEq("R3", "no prefetch after warm-up misses", 32'(pfValid), 32'd0);
  endtask

  task automatic testDistance();
    resetDut();
    for (int i = 1; i <= 5; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0001, 1'b1);
    checkEq("R2", "prefetch valid after revisit", 32'(pfValid), 32'd1);
    checkEq("R2", "target is fourth later miss", 32'(pfAddr), 32'd5);
  endtask

  task automatic testFlag();
    resetDut();
    for (int i = 1; i <= 4; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0005, 1'b0);  // learned target does not miss real cache
    miss(16'h0001, 1'b1);
    checkEq("R5", "flag clear blocks prefetch", 32'(pfValid), 32'd0);
    resetDut();
    for (int i = 1; i <= 5; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0001, 1'b1);
    checkEq("R5", "flag set gives prefetch", 32'(pfAddr), 32'd5);
    miss(16'h0006, 1'b1);
    miss(16'h0007, 1'b1);
    miss(16'h0002, 1'b1);
    miss(16'h0005, 1'b0);  // retrains row of 1 with a clear flag
    miss(16'h0001, 1'b1);
    checkEq("R5", "retrain clears flag", 32'(pfValid), 32'd0);
  endtask

  task automatic testAlias();
    resetDut();
    for (int i = 1; i <= 5; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0041, 1'b1);  // same row as 1, tag 1 instead of 0
    checkEq("R4", "tag mismatch gives no prefetch", 32'(pfValid), 32'd0);
  endtask

  task automatic testHandshake();
    resetDut();
    pfReady = 1'b0;
    for (int i = 1; i <= 5; i++) miss(ADDR_W'(i), 1'b1);
    miss(16'h0001, 1'b1);
    checkEq("R6", "request rises after miss", 32'(pfValid), 32'd1);
    checkEq("R6", "request address", 32'(pfAddr), 32'd5);
    repeat (3) @(negedge clk);
    checkEq("R7", "held valid while not ready", 32'(pfValid), 32'd1);
    checkEq("R7", "held address while not ready", 32'(pfAddr), 32'd5);
    miss(16'h0002, 1'b1);  // would predict 1 but slot is busy
    checkEq("R8", "pending address kept", 32'(pfAddr), 32'd5);
    pfReady = 1'b1;
    @(negedge clk);
    checkEq("R7", "request drops after accept", 32'(pfValid), 32'd0);
  endtask

  task automatic testIdle();
    resetDut();
    for (int i = 1; i <= 4; i++) miss(ADDR_W'(i), 1'b1);
    @(negedge clk);
    missAddr = 16'h0005; realMiss = 1'b1;  // strobe stays low
    repeat (3) @(negedge clk);
    realMiss = 1'b0;
    miss(16'h0006, 1'b1);
    miss(16'h0001, 1'b1);
    checkEq("R1", "idle cycles ignored, valid", 32'(pfValid), 32'd1);
    checkEq("R1", "idle cycles ignored, target", 32'(pfAddr), 32'd6);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    testReset();
    testWarmup();
    testDistance();
    testFlag();
    testAlias();
    testHandshake();
    testIdle();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule